// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Register

This block holds the 16-bit status word of one channel in a descriptor-list DMA engine that moves samples between memory and a FIFO. The surrounding datapath is not part of it. It reports what happened through single-cycle event pulses and steady level inputs. The register turns those pulses into sticky flags that software clears by writing ones. It also registers two state bits, and it raises an interrupt request whenever an enabled sticky flag is set.

Each sticky flag is qualified before it sets.
- The FIFO error counts only an error that matches the channel direction, and only while more valid buffers remain.
- The completion flag needs the descriptor's interrupt-on-completion bit.
- The last-buffer flag is set by a different event for each direction: a receive channel uses the memory write, and a transmit channel uses the fetch.

A small register bus reads the status word alone or together with the two neighbouring index bytes in one 32-bit read. Status bits are cleared through the same bus.

Top module: `dma_chan_status`

## Requirements
- R1: After reset the status word reads 0x0001: only bit 0 (halted) is set. The interrupt output is low.
- R2: Bit 4 (FIFO error) sets on the clock after one of two events, provided `more_valid` is high. With `is_rx`=1 the event is `ev_overrun`. With `is_rx`=0 the event is `ev_underrun`. The event of the other direction has no effect, and so does any event while `more_valid` is low.
- R3: Bit 3 (buffer complete) sets on the clock after `ev_buf_done` only if `desc_ioc` is high in that same cycle.
- R4: Bit 2 (last buffer) sets on the clock after `ev_last_written` when `is_rx`=1, or after `ev_last_fetched` when `is_rx`=0. The event of the other direction has no effect.
- R5: Bits 4:2 are cleared one clock after the write that clears them. A write with value 1 in a bit clears that bit. Writing 0 leaves a bit unchanged, and so does writing to bits 15:5, bit 1 or bit 0.
  - A byte or word write at address 6 takes the status bits from `acc_wdata[4:2]`.
  - A 32-bit write at address 4 takes them from `acc_wdata[20:18]`.
  - Writes at addresses 4, 5 and 7 have no effect on the status bits.
- R6: If a set event and a write-1 clear hit the same sticky bit in the same cycle, the bit ends up set.
- R7: Bit 1 is registered from `cur_eq_last & last_done`. It follows that input with one clock of delay and cannot be written.
- R8: Bit 0 is registered from `(~run_en & eng_idle) | (cur_eq_last & last_done)`. It has one clock of delay and cannot be written.
- R9: `irq` is the OR of bit 4 AND `ien_fifo`, bit 3 AND `ien_ioc`, and bit 2 AND `ien_lvb`. It drops in the cycle after software clears the last enabled flag.
- R10: Reads decode `acc_size` as 0 for a byte, 1 for a word and 2 for a 32-bit access.
  - A 32-bit read at address 4 returns {status, `last_idx`, `cur_idx`}.
  - A word read at address 6 returns the status word in bits 15:0.
  - Byte reads at addresses 4, 5, 6 and 7 return `cur_idx`, `last_idx`, status[7:0] and status[15:8].
  - Bits 15:5 of the status word always read 0.
- R11: A 32-bit access whose address is not 4 crosses a 32-bit boundary or lies outside the block. Such a read returns 0, and such a write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_rx | input | 1 | Channel direction: 1 receive, 0 transmit |
| more_valid | input | 1 | More valid buffers remain to be processed |
| ev_overrun | input | 1 | Receive FIFO overrun pulse |
| ev_underrun | input | 1 | Transmit FIFO underrun pulse |
| ev_buf_done | input | 1 | Last sample of a buffer processed |
| desc_ioc | input | 1 | Interrupt-on-completion bit of the current descriptor |
| ev_last_fetched | input | 1 | Last valid buffer fetched (transmit) |
| ev_last_written | input | 1 | Last valid buffer written to memory (receive) |
| cur_eq_last | input | 1 | Current index equals last valid index |
| last_done | input | 1 | Buffer at the current index has been processed |
| run_en | input | 1 | Run control bit |
| eng_idle | input | 1 | DMA engines idle |
| ien_fifo | input | 1 | Interrupt enable for FIFO error |
| ien_ioc | input | 1 | Interrupt enable for buffer completion |
| ien_lvb | input | 1 | Interrupt enable for last buffer |
| cur_idx | input | 8 | Byte at address 4, supplied by the neighbouring register |
| last_idx | input | 8 | Byte at address 5, supplied by the neighbouring register |
| acc_wr | input | 1 | Write strobe |
| acc_size | input | 2 | Access size: 0 byte, 1 word, 2 32-bit |
| acc_addr | input | 4 | Byte address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from address and size |
| irq | output | 1 | Interrupt request |

## Verification
A hardware set event and a software write-one clear can land on the same sticky bit in the same clock. Random stimulus provokes this often, because it draws the event pulses and the clear writes independently every cycle. A directed case also fires an overrun together with a bit 4 clear in one cycle. After that clock edge the bench reads the status word and requires the bit to be set. It then clears the bit alone and requires it to drop.

// File: rtl/dma_chan_status.sv
`timescale 1ns/1ps
module dma_chan_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        is_rx,
  input  logic        more_valid,
  input  logic        ev_overrun,
  input  logic        ev_underrun,
  input  logic        ev_buf_done,
  input  logic        desc_ioc,
  input  logic        ev_last_fetched,
  input  logic        ev_last_written,
  input  logic        cur_eq_last,
  input  logic        last_done,
  input  logic        run_en,
  input  logic        eng_idle,
  input  logic        ien_fifo,
  input  logic        ien_ioc,
  input  logic        ien_lvb,
  input  logic [7:0]  cur_idx,
  input  logic [7:0]  last_idx,
  input  logic        acc_wr,
  input  logic [1:0]  acc_size,
  input  logic [3:0]  acc_addr,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  output logic        irq
);
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_DW   = 2'd2;

  logic fifo_q, ioc_q, lvb_q, celv_q, halt_q;
  logic [15:0] status;
  logic [2:0] clr, set;
  logic wr_lo, wr_dw, at_end;

  assign status = {11'b0, fifo_q, ioc_q, lvb_q, celv_q, halt_q};

  assign wr_lo = acc_wr && (acc_size == SZ_BYTE || acc_size == SZ_WORD) && acc_addr == 4'h6;
  assign wr_dw = acc_wr && acc_size == SZ_DW && acc_addr == 4'h4;
  assign clr   = wr_lo ? acc_wdata[4:2] : (wr_dw ? acc_wdata[20:18] : 3'b000);

  assign set[2] = more_valid & (is_rx ? ev_overrun : ev_underrun);
  assign set[1] = ev_buf_done & desc_ioc;
  assign set[0] = is_rx ? ev_last_written : ev_last_fetched;

  assign at_end = cur_eq_last & last_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_q <= 1'b0;
      ioc_q  <= 1'b0;
      lvb_q  <= 1'b0;
      celv_q <= 1'b0;
      halt_q <= 1'b1;
    end else begin
      fifo_q <= set[2] | (fifo_q & ~clr[2]);
      ioc_q  <= set[1] | (ioc_q  & ~clr[1]);
      lvb_q  <= set[0] | (lvb_q  & ~clr[0]);
      celv_q <= at_end;
      halt_q <= (~run_en & eng_idle) | at_end;
    end
  end

  assign irq = (fifo_q & ien_fifo) | (ioc_q & ien_ioc) | (lvb_q & ien_lvb);

  always_comb begin
    acc_rdata = 32'b0;
    case ({acc_size, acc_addr})
      {SZ_DW,   4'h4}: acc_rdata = {status, last_idx, cur_idx};
      {SZ_WORD, 4'h4}: acc_rdata = {16'b0, last_idx, cur_idx};
      {SZ_WORD, 4'h6}: acc_rdata = {16'b0, status};
      {SZ_BYTE, 4'h4}: acc_rdata = {24'b0, cur_idx};
      {SZ_BYTE, 4'h5}: acc_rdata = {24'b0, last_idx};
      {SZ_BYTE, 4'h6}: acc_rdata = {24'b0, status[7:0]};
      {SZ_BYTE, 4'h7}: acc_rdata = {24'b0, status[15:8]};
      default:         acc_rdata = 32'b0;
    endcase
  end
endmodule

module dma_chan_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        is_rx,
  input logic        more_valid,
  input logic        ev_overrun,
  input logic        ev_underrun,
  input logic        ev_buf_done,
  input logic        desc_ioc,
  input logic        run_en,
  input logic        eng_idle,
  input logic        ien_fifo,
  input logic        ien_ioc,
  input logic        ien_lvb,
  input logic [1:0]  acc_size,
  input logic [3:0]  acc_addr,
  input logic [31:0] acc_rdata,
  input logic        irq,
  input logic        fifo_q,
  input logic        ioc_q,
  input logic        halt_q
);
  assert_fifo_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (more_valid && (is_rx ? ev_overrun : ev_underrun)) |=> fifo_q);

  assert_fifo_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_q && !more_valid) |=> !fifo_q);

  assert_ioc_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ioc_q && !desc_ioc) |=> !ioc_q);

  assert_halt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && eng_idle) |=> halt_q);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_fifo && !ien_ioc && !ien_lvb) |-> !irq);

  assert_resv_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'd1 && acc_addr == 4'h6) |-> acc_rdata[31:5] == 27'b0);
endmodule

bind dma_chan_status dma_chan_status_chk u_chk (.*);

// File: tb/sim_dma_chan_status.sv
`timescale 1ns/1ps
module sim_dma_chan_status;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, is_rx, more_valid, ev_overrun, ev_underrun, ev_buf_done, desc_ioc;
  logic ev_last_fetched, ev_last_written, cur_eq_last, last_done, run_en, eng_idle;
  logic ien_fifo, ien_ioc, ien_lvb, acc_wr, irq;
  logic [7:0] cur_idx, last_idx;
  logic [1:0] acc_size;
  logic [3:0] acc_addr;
  logic [31:0] acc_wdata, acc_rdata;

  dma_chan_status u0 (.*);

  int total = 0, bad = 0;
  logic [2:0] mf;
  logic mc, mh;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [2:0] clr_of(input logic w, input logic [1:0] sz,
                                        input logic [3:0] a, input logic [31:0] d);
    if (!w) return 3'b0;
    if ((sz == 2'd0 || sz == 2'd1) && a == 4'h6) return d[4:2];
    if (sz == 2'd2 && a == 4'h4) return d[20:18];
    return 3'b0;
  endfunction

  function automatic logic [2:0] set_of();
    logic f, c, l;
    f = more_valid && (is_rx ? ev_overrun : ev_underrun);
    c = ev_buf_done && desc_ioc;
    l = is_rx ? ev_last_written : ev_last_fetched;
    return {f, c, l};
  endfunction

  function automatic logic [15:0] mstat();
    return {11'b0, mf, mc, mh};
  endfunction

  task automatic idle_in();
    {ev_overrun, ev_underrun, ev_buf_done, desc_ioc, ev_last_fetched, ev_last_written} = '0;
    acc_wr = 0; acc_size = 2'd1; acc_addr = 4'h6; acc_wdata = '0;
  endtask

  // Called just after a falling edge with inputs set; advances one clock and checks.
  task automatic step(input string r);
    logic [2:0] nf;
    logic nc, nh;
    nf = set_of() | (mf & ~clr_of(acc_wr, acc_size, acc_addr, acc_wdata));
    nc = cur_eq_last & last_done;
    nh = (~run_en & eng_idle) | nc;
    @(posedge clk);
    mf = nf; mc = nc; mh = nh;
    #1;
    idle_in();
    #0.5;
    chk(r, {16'b0, acc_rdata[15:0]}, {16'b0, mstat()});
    chk("R9 irq", {31'b0, irq}, {31'b0, |(mf & {ien_fifo, ien_ioc, ien_lvb})});
    @(negedge clk);
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    idle_in();
    is_rx = 1; more_valid = 0; cur_eq_last = 0; last_done = 0; run_en = 1; eng_idle = 0;
    ien_fifo = 1; ien_ioc = 1; ien_lvb = 1; cur_idx = 8'h3A; last_idx = 8'h5C;
    rst_n = 0;
    mf = 3'b0; mc = 0; mh = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset status", acc_rdata, 32'h0000_0001);
    chk("R1 reset irq", {31'b0, irq}, 32'b0);
    rst_n = 1;
    @(negedge clk);

    // R2: wrong-direction and no-more-valid are ignored
    is_rx = 1; more_valid = 1; ev_underrun = 1; step("R2 rx ignores underrun");
    is_rx = 0; more_valid = 0; ev_underrun = 1; step("R2 tx underrun without more_valid");
    is_rx = 0; more_valid = 1; ev_underrun = 1; step("R2 tx underrun sets");
    // R6: set and clear in the same cycle
    is_rx = 1; ev_overrun = 1; acc_wr = 1; acc_size = 2'd1; acc_addr = 4'h6; acc_wdata = 32'h10;
    step("R6 set beats clear");
    chk("R6 bit4", {31'b0, acc_rdata[4]}, 32'd1);
    acc_wr = 1; acc_size = 2'd1; acc_addr = 4'h6; acc_wdata = 32'h10; step("R5 clear bit4");
    // R3 / R4
    ev_buf_done = 1; desc_ioc = 0; step("R3 no ioc");
    ev_buf_done = 1; desc_ioc = 1; step("R3 ioc sets");
    is_rx = 1; ev_last_fetched = 1; step("R4 rx ignores fetch");
    is_rx = 0; ev_last_fetched = 1; step("R4 tx fetch sets");
    // R5: zero writes, RO bits
    acc_wr = 1; acc_size = 2'd1; acc_addr = 4'h6; acc_wdata = 32'hFFE3; step("R5 zeros in 4:2 keep");
    acc_wr = 1; acc_size = 2'd0; acc_addr = 4'h7; acc_wdata = 32'hFF; step("R5 byte 7 write ignored");
    // R11: misaligned 32-bit write and read
    acc_wr = 1; acc_size = 2'd2; acc_addr = 4'h5; acc_wdata = '1; step("R11 misaligned write");
    acc_size = 2'd2; acc_addr = 4'h5; #0.5;
    chk("R11 misaligned read", acc_rdata, 32'h0);
    // R10: composed read and byte reads
    acc_size = 2'd2; acc_addr = 4'h4; #0.5;
    chk("R10 dword read", acc_rdata, {mstat(), 8'h5C, 8'h3A});
    acc_size = 2'd0; acc_addr = 4'h7; #0.5;
    chk("R10 byte 7", acc_rdata, 32'h0);
    acc_size = 2'd0; acc_addr = 4'h5; #0.5;
    chk("R10 byte 5", acc_rdata, 32'h5C);
    acc_size = 2'd1; acc_addr = 4'h6;
    // R7 / R8
    cur_eq_last = 1; last_done = 1; step("R7 celv rises");
    cur_eq_last = 0; run_en = 1; step("R8 running clears halt");
    run_en = 0; eng_idle = 1; step("R8 idle halts");
    // R5 via dword clear at address 4
    acc_wr = 1; acc_size = 2'd2; acc_addr = 4'h4; acc_wdata = 32'h001C_0000; step("R5 dword clear");

    for (int i = 0; i < 600; i++) begin
      is_rx = $urandom % 2; more_valid = $urandom % 2;
      ev_overrun = ($urandom % 4) == 0; ev_underrun = ($urandom % 4) == 0;
      ev_buf_done = ($urandom % 4) == 0; desc_ioc = $urandom % 2;
      ev_last_fetched = ($urandom % 5) == 0; ev_last_written = ($urandom % 5) == 0;
      cur_eq_last = $urandom % 2; last_done = $urandom % 2;
      run_en = $urandom % 2; eng_idle = $urandom % 2;
      ien_fifo = $urandom % 2; ien_ioc = $urandom % 2; ien_lvb = $urandom % 2;
      acc_wr = ($urandom % 3) == 0;
      case ($urandom % 6)
        0: begin acc_size = 2'd1; acc_addr = 4'h6; end
        1: begin acc_size = 2'd0; acc_addr = 4'h6; end
        2: begin acc_size = 2'd2; acc_addr = 4'h4; end
        3: begin acc_size = 2'd0; acc_addr = 4'h7; end
        4: begin acc_size = 2'd1; acc_addr = 4'h4; end
        default: begin acc_size = 2'd2; acc_addr = 4'h6; end
      endcase
      acc_wdata = $urandom;
      step("R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule